// File: doc/BRIEF.md
# Paged GROM Slave Emulator

This block stands in for one slow, byte-wide, auto-incrementing graphics ROM that shares a bus with others of its kind. A host selects the device with an active-low chip select, picks the address port or the data port with a mode input, and picks read or write with a direction input. The device keeps a 16-bit address counter. The host loads it with two byte writes to the address port. Each data read returns the byte at the counter and then advances it, so a run of bytes needs only one address load.

Every device on the shared bus performs every cycle and keeps its own copy of the counter, whether or not the address falls inside its window. A window parameter (the top bits of the address) decides whether this device owns the current byte. Only the owner drives the data bus on a data read. The address port always answers, so the loaded address can be read back even from an empty region. Each cycle holds a not-ready output low for a set number of cycles. The cycle that loads the low address byte also fetches the byte at the new address ahead of time, so it takes longer. Once a cycle has finished, the ready output stays high until the host drops chip select. The outputs of all devices are combined outside the block as an open-collector line.

The array contents are computed, not stored. Entry `i` holds `(i*37 + 0x5A) mod 256` with the defaults. It is indexed by the low 6 address bits, and the array is read-only.

Top module: `grom_slave`

## Requirements
- R1: After reset `rdy` and `rd_oe` are low and the address counter is 0x0000.
- R2: Address writes (`amode`=1, `rd`=0) load the high byte first and then the low byte. A high-byte write finishes with `rdy` rising LAT_OP (default 14) cycles after select is sampled.
- R3: A low-byte address write prefetches the byte at the new address. Its `rdy` rises LAT_PF (default 30) cycles after select is sampled.
- R4: A data read (`amode`=0, `rd`=1) returns the array byte at the current address, `(addr[5:0]*37 + 0x5A) mod 256`, and then increments the address.
- R5: `rdy` is low except after a cycle has finished. It then stays high while `cs_n` stays low, and it is low once `cs_n` is high.
- R6: `rd_oe` is high only while `rdy` is high on a read. On a data read it also needs `addr[15:13]` equal to BASE_PAGE (default 3, window 0x6000-0x7FFF) at the time of the read.
- R7: A data read outside the window leaves `rd_oe` low and still advances the address.
- R8: Address reads (`amode`=1, `rd`=1) return the high byte and then the low byte of the counter, are driven in any window, and leave the counter unchanged.
- R9: Any data-port cycle returns the address byte pointer to the high byte.
- R10: The address counter wraps from 0xFFFF to 0x0000.
- R11: A data write (`amode`=0, `rd`=0) does not drive the bus, does not change the array, and advances the address by one.
- R12: Data reads, data writes and address reads finish LAT_OP cycles after select is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (slow device clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| amode | input | 1 | 1 = address port, 0 = data port |
| rd | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Byte written by the host |
| rd_data | output | 8 | Byte returned to the host |
| rd_oe | output | 1 | Data bus drive enable |
| rdy | output | 1 | High = cycle finished (wired-AND outside) |

## Verification
On every cycle the assertions check the following. Ready holds until deselect. The drive enable appears only with ready on a read cycle. Returned data is stable while driven. Ready never rises before the base latency has passed since select. The counter moves only on the edge that finishes a cycle. The directed scenarios are needed to show the values themselves: the array bytes, the order of the address bytes, pointer recovery after a data cycle, the wrap at 0xFFFF, the longer prefetch cycle, and that an unowned or written cycle advances the counter without driving the bus.

// File: rtl/grom_pkg.sv
package grom_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} st_e;
  typedef enum logic [1:0] {OP_DRD, OP_DWR, OP_ARD, OP_AWR} op_e;

  function automatic op_e op_decode(input logic amode, input logic rd);
    case ({amode, rd})
      2'b01:   return OP_DRD;
      2'b00:   return OP_DWR;
      2'b11:   return OP_ARD;
      default: return OP_AWR;
    endcase
  endfunction
endpackage

// File: rtl/grom_rom.sv
module grom_rom #(
  parameter int          DEPTH = 64,
  parameter int          MULT  = 37,
  parameter logic [7:0]  SEED  = 8'h5A,
  localparam int         IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       q
);
  logic [7:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign tbl[g] = 8'((g * MULT + int'(SEED)) % 256);
  end

  assign q = tbl[idx];
endmodule

// File: rtl/grom_seq.sv
module grom_seq
  import grom_pkg::*;
#(
  parameter int LAT_OP = 14,
  parameter int LAT_PF = 30,
  localparam int CW = $clog2(LAT_PF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  op_e  op_in,
  input  logic long_op,
  output st_e  st,
  output op_e  op,
  output logic fin
);
  st_e           st_q, st_n;
  op_e           op_q, op_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    op_n  = op_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_IDLE: if (sel) begin
        st_n  = ST_BUSY;
        op_n  = op_in;
        cnt_n = long_op ? CW'(LAT_PF - 1) : CW'(LAT_OP - 1);
      end
      ST_BUSY: begin
        if (cnt_q == '0) st_n = ST_DONE;
        else             cnt_n = cnt_q - 1'b1;
      end
      ST_DONE: if (!sel) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_DRD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      op_q  <= op_n;
      cnt_q <= cnt_n;
    end
  end

  assign st  = st_q;
  assign op  = op_q;
  assign fin = (st_q == ST_BUSY) && (cnt_q == '0);
endmodule

// File: rtl/grom_addr.sv
module grom_addr
  import grom_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter int         PAGE_W    = 3,
  parameter logic [PAGE_W-1:0] BASE_PAGE = 3'd3,
  localparam int        IDX_W     = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fin,
  input  op_e         op,
  input  logic [7:0]  wr_data,
  output logic [15:0] addr,
  output logic        ptr_lo,
  output logic [7:0]  out_byte,
  output logic        out_own
);
  logic [15:0] addr_q, addr_n, addr_inc;
  logic        ptr_q, ptr_n;
  logic [7:0]  dbuf_q, dbuf_n;
  logic        pfv_q, pfv_n;
  logic [7:0]  out_q, out_n;
  logic        own_q, own_n;
  logic [7:0]  cur_byte, nxt_byte;
  logic [IDX_W-1:0] nxt_idx;
  logic        own_cur;

  assign addr_inc = addr_q + 16'd1;
  assign nxt_idx  = (op == OP_AWR) ? wr_data[IDX_W-1:0] : addr_inc[IDX_W-1:0];
  assign own_cur  = (addr_q[15 -: PAGE_W] == BASE_PAGE);

  grom_rom #(.DEPTH(DEPTH)) u_rom_cur (.idx(addr_q[IDX_W-1:0]), .q(cur_byte));
  grom_rom #(.DEPTH(DEPTH)) u_rom_nxt (.idx(nxt_idx),           .q(nxt_byte));

  always_comb begin
    addr_n = addr_q;
    ptr_n  = ptr_q;
    dbuf_n = dbuf_q;
    pfv_n  = pfv_q;
    out_n  = out_q;
    own_n  = own_q;
    if (fin) begin
      case (op)
        OP_DRD: begin
          out_n  = pfv_q ? dbuf_q : cur_byte;
          own_n  = own_cur;
          addr_n = addr_inc;
          dbuf_n = nxt_byte;
          pfv_n  = 1'b1;
          ptr_n  = 1'b0;
        end
        OP_DWR: begin
          addr_n = addr_inc;
          dbuf_n = nxt_byte;
          pfv_n  = 1'b1;
          ptr_n  = 1'b0;
        end
        OP_ARD: begin
          out_n = ptr_q ? addr_q[7:0] : addr_q[15:8];
          ptr_n = ~ptr_q;
        end
        default: begin
          if (!ptr_q) begin
            addr_n[15:8] = wr_data;
            pfv_n        = 1'b0;
            ptr_n        = 1'b1;
          end else begin
            addr_n[7:0] = wr_data;
            dbuf_n      = nxt_byte;
            pfv_n       = 1'b1;
            ptr_n       = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ptr_q  <= 1'b0;
      dbuf_q <= '0;
      pfv_q  <= 1'b0;
      out_q  <= '0;
      own_q  <= 1'b0;
    end else if (fin) begin
      addr_q <= addr_n;
      ptr_q  <= ptr_n;
      dbuf_q <= dbuf_n;
      pfv_q  <= pfv_n;
      out_q  <= out_n;
      own_q  <= own_n;
    end
  end

  assign addr     = addr_q;
  assign ptr_lo   = ptr_q;
  assign out_byte = out_q;
  assign out_own  = own_q;
endmodule

// File: rtl/grom_slave.sv
module grom_slave
  import grom_pkg::*;
#(
  parameter int                LAT_OP    = 14,
  parameter int                LAT_PF    = 30,
  parameter int                DEPTH     = 64,
  parameter int                PAGE_W    = 3,
  parameter logic [PAGE_W-1:0] BASE_PAGE = 3'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       amode,
  input  logic       rd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rd_oe,
  output logic       rdy
);
  logic        sel;
  op_e         op_in, op_q;
  st_e         st_q;
  logic        fin, ptr_lo, long_op, own_q;
  logic [15:0] cur_addr;
  logic [7:0]  out_byte;

  assign sel     = ~cs_n;
  assign op_in   = op_decode(amode, rd);
  assign long_op = (op_in == OP_AWR) && ptr_lo;

  grom_seq #(.LAT_OP(LAT_OP), .LAT_PF(LAT_PF)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel(sel), .op_in(op_in),
    .long_op(long_op), .st(st_q), .op(op_q), .fin(fin)
  );

  grom_addr #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .BASE_PAGE(BASE_PAGE)) u_addr (
    .clk(clk), .rst_n(rst_n), .fin(fin), .op(op_q), .wr_data(wr_data),
    .addr(cur_addr), .ptr_lo(ptr_lo), .out_byte(out_byte), .out_own(own_q)
  );

  assign rdy     = (st_q == ST_DONE) && sel;
  assign rd_oe   = rdy && ((op_q == OP_ARD) || ((op_q == OP_DRD) && own_q));
  assign rd_data = out_byte;
endmodule

// File: rtl/grom_slave_chk.sv
module grom_slave_chk
  import grom_pkg::*;
#(
  parameter int LAT_OP = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd,
  input logic        rd_oe,
  input logic        rdy,
  input logic [7:0]  rd_data,
  input st_e         st_q,
  input logic [15:0] cur_addr
);
  logic [7:0] sel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sel_cnt <= '0;
    else if (cs_n)            sel_cnt <= '0;
    else if (sel_cnt != 8'hFF) sel_cnt <= sel_cnt + 8'd1;
  end

  assert_rdy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !cs_n) |=> (rdy || cs_n));

  assert_oe_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rdy && rd && !cs_n));

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && $past(rd_oe)) |-> $stable(rd_data));

  assert_min_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (sel_cnt >= 8'(LAT_OP)));

  assert_addr_moves_at_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_addr) |-> ($past(st_q) == ST_BUSY));
endmodule

bind grom_slave grom_slave_chk #(.LAT_OP(LAT_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd(rd), .rd_oe(rd_oe),
  .rdy(rdy), .rd_data(rd_data), .st_q(st_q), .cur_addr(cur_addr)
);

// File: tb/sim_grom_slave.sv
module sim_grom_slave;
  localparam int LAT_OP = 14;
  localparam int LAT_PF = 30;

  logic       clk, rst_n, cs_n, amode, rd;
  logic [7:0] wr_data, rd_data;
  logic       rd_oe, rdy;
  int         total, bad;
  bit         done;

  grom_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .amode(amode), .rd(rd),
    .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_rom(input logic [15:0] a);
    return 8'((int'(a[5:0]) * 37 + 'h5A) % 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; hold = extra cycles to keep select after ready
  task automatic bus_op(input logic am, input logic r, input logic [7:0] wd,
                        input int hold, output logic [7:0] q, output logic oe,
                        output int n);
    bit early_oe;
    early_oe = 0;
    n = 0;
    @(negedge clk);
    cs_n = 1'b0; amode = am; rd = r; wr_data = wd;
    do begin
      @(negedge clk);
      n++;
      if (rd_oe && !rdy) early_oe = 1;
    end while (!rdy && n < 1000);
    q  = rd_data;
    oe = rd_oe;
    check(!early_oe, "R6 oe before ready", 1, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rdy == 1'b1, "R5 ready held", rdy, 1);
      check(rd_oe == oe, "R6 oe held", rd_oe, oe);
    end
    cs_n = 1'b1;
    @(negedge clk);
    check(rdy == 1'b0 && rd_oe == 1'b0, "R5 release after deselect", {rdy, rd_oe}, 0);
  endtask

  task automatic load_addr(input logic [15:0] a);
    logic [7:0] q; logic oe; int n;
    bus_op(1'b1, 1'b0, a[15:8], 0, q, oe, n);
    bus_op(1'b1, 1'b0, a[7:0], 0, q, oe, n);
  endtask

  task automatic read_addr(output logic [15:0] a);
    logic [7:0] q; logic oe; int n;
    bus_op(1'b1, 1'b1, 8'h00, 0, q, oe, n);
    a[15:8] = q;
    check(oe == 1'b1, "R8 address read driven", oe, 1);
    bus_op(1'b1, 1'b1, 8'h00, 0, q, oe, n);
    a[7:0] = q;
  endtask

  task automatic t_reset();
    logic [15:0] a;
    check(rdy == 1'b0, "R1 rdy after reset", rdy, 0);
    check(rd_oe == 1'b0, "R1 rd_oe after reset", rd_oe, 0);
    read_addr(a);
    check(a == 16'h0000, "R1 counter after reset", a, 0);
  endtask

  task automatic t_addr_load();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    bus_op(1'b1, 1'b0, 8'h60, 0, q, oe, n);
    check(n == LAT_OP + 1, "R2 high byte latency", n, LAT_OP + 1);
    check(oe == 1'b0, "R2 no drive on address write", oe, 0);
    bus_op(1'b1, 1'b0, 8'h10, 0, q, oe, n);
    check(n == LAT_PF + 1, "R3 prefetch latency", n, LAT_PF + 1);
    bus_op(1'b1, 1'b1, 8'h00, 0, q, oe, n);
    check(n == LAT_OP + 1, "R12 address read latency", n, LAT_OP + 1);
    check(q == 8'h60, "R8 high byte first", q, 8'h60);
    bus_op(1'b1, 1'b1, 8'h00, 0, q, oe, n);
    check(q == 8'h10, "R8 low byte second", q, 8'h10);
    read_addr(a);
    check(a == 16'h6010, "R8 read leaves counter", a, 16'h6010);
  endtask

  task automatic t_seq_read();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    load_addr(16'h603E);
    for (int i = 0; i < 4; i++) begin
      bus_op(1'b0, 1'b1, 8'h00, 0, q, oe, n);
      check(q == exp_rom(16'h603E + 16'(i)), "R4 sequential byte", q, exp_rom(16'h603E + 16'(i)));
      check(oe == 1'b1, "R6 owned read driven", oe, 1);
      if (i == 0) check(n == LAT_OP + 1, "R12 data read latency", n, LAT_OP + 1);
    end
    read_addr(a);
    check(a == 16'h6042, "R4 address incremented", a, 16'h6042);
  endtask

  task automatic t_foreign();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    load_addr(16'h2005);
    bus_op(1'b0, 1'b1, 8'h00, 0, q, oe, n);
    check(oe == 1'b0, "R7 unowned read not driven", oe, 0);
    read_addr(a);
    check(a == 16'h2006, "R7 unowned read advances", a, 16'h2006);
  endtask

  task automatic t_hold();
    logic [7:0] q; logic oe; int n;
    load_addr(16'h6001);
    bus_op(1'b0, 1'b1, 8'h00, 6, q, oe, n);
    check(q == exp_rom(16'h6001), "R5 held read data", q, exp_rom(16'h6001));
  endtask

  task automatic t_ptr();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    bus_op(1'b1, 1'b0, 8'h12, 0, q, oe, n);
    bus_op(1'b0, 1'b1, 8'h00, 0, q, oe, n);
    load_addr(16'h6005);
    read_addr(a);
    check(a == 16'h6005, "R9 pointer back to high", a, 16'h6005);
  endtask

  task automatic t_wrap();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    load_addr(16'hFFFF);
    bus_op(1'b0, 1'b1, 8'h00, 0, q, oe, n);
    read_addr(a);
    check(a == 16'h0000, "R10 wrap to zero", a, 0);
  endtask

  task automatic t_dwrite();
    logic [7:0] q; logic oe; int n; logic [15:0] a;
    load_addr(16'h6010);
    bus_op(1'b0, 1'b0, 8'hEE, 0, q, oe, n);
    check(oe == 1'b0, "R11 write not driven", oe, 0);
    check(n == LAT_OP + 1, "R12 data write latency", n, LAT_OP + 1);
    read_addr(a);
    check(a == 16'h6011, "R11 write advances", a, 16'h6011);
    load_addr(16'h6010);
    bus_op(1'b0, 1'b1, 8'h00, 0, q, oe, n);
    check(q == exp_rom(16'h6010), "R11 array unchanged", q, exp_rom(16'h6010));
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    cs_n = 1'b1; amode = 1'b0; rd = 1'b0; wr_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_load();
    t_seq_read();
    t_foreign();
    t_hold();
    t_ptr();
    t_wrap();
    t_dwrite();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule